// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short shift register holding the outcomes of the most recently resolved branches anywhere in the program. On a lookup, a few low bits of the branch address are joined with that history pattern. The result selects one 2-bit saturating counter in a single shared table, and the counter's upper bit is the prediction. The same address can therefore have a different prediction for each recent-outcome pattern. Entries are not tagged, so two branches whose selected address bits match share counters.

The fetch side presents a PC and receives the prediction in the same cycle. It also receives the history value that was used, and carries that value down the pipeline. When the branch resolves, the execute side returns the PC, the real outcome and that saved history. Only the counter chosen by the returned history is moved one step toward the outcome, and the outcome is shifted into the global history. The history width is a parameter. With it set to zero, the block becomes a plain address-indexed table of 2-bit counters.

Top module: `gcp_predictor`

## Requirements
- R1: After a synchronous active-low reset, every counter holds weak-not-taken (value 1), so every lookup predicts not taken, and the history register reads 0.
- R2: `lk_pred` is 1 exactly when the selected counter holds 2 (weak-taken) or 3 (strong-taken). Counter encoding: 0 strong-not-taken, 1 weak-not-taken, 2 weak-taken, 3 strong-taken.
- R3: A lookup selects the counter at index {PC[9:2], H}, where H is the current 2-bit history register and forms the low two index bits.
- R4: A resolve with outcome taken adds 1 to the selected counter, and one with outcome not taken subtracts 1. The counter saturates at 3 and at 0 and never wraps.
- R5: A counter at a strong state keeps its predicted direction after one opposite outcome, and flips only after a second consecutive one.
- R6: A resolve changes only the counter at {PC[9:2], rs_hist}. Counters for the same address under other history values are untouched. PC bits outside [9:2] take no part in selection, so addresses that differ only there share a counter.
- R7: Each resolve shifts the history left by one, with the actual outcome entering at bit 0. Without a resolve, the history holds its value.
- R8: The counter update uses the history value returned on `rs_hist`, not the current contents of the history register.
- R9: `lk_hist` shows the current history register, which is the value used for the prediction in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | 32 | Address of the branch being looked up |
| lk_pred | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | 2 | History used for this prediction, to be sent back on resolve |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | 32 | Address of the resolving branch |
| rs_taken | input | 1 | Actual outcome of the resolving branch |
| rs_hist | input | 2 | History value that was captured when this branch was predicted |

## Verification
The main sequence trains one address under each of its four history patterns in turn. This separates the four counters of one address set and shows that the history, and not only the address, picks the counter. Some resolves return a stale history that differs from the register's contents, so an update aimed at the register's value rather than the returned one lands in the wrong counter and shows up at a later lookup. Runs of same-direction and alternating outcomes drive counters into both saturation limits and through the two-miss flip. Lookups at aliased addresses and at a neighbouring address confirm which counters are shared and which stay untouched.

// File: rtl/gcp_pkg.sv
// Shared types and helpers for the global-history correlating predictor.
// Assumes a 2-bit counter encoding in which the upper bit is the direction.
package gcp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_e;

    // Move a counter one step toward the observed outcome, saturating at the ends.
    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_ST) nxt = ctr_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_SNT) nxt = ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/gcp_hist_reg.sv
// Global outcome history register.
// Shifts left on every resolve, with the new outcome at bit 0. With HIST_W of
// zero there is no register and the output is tied to zero (one padding bit).
module gcp_hist_reg #(
    parameter int HIST_W = 2,
    parameter int HW_P   = (HIST_W > 0) ? HIST_W : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            shift_bit,
    output logic [HW_P-1:0] hist_o
);

    generate
        if (HIST_W == 0) begin : g_none
            logic unused_shift;
            assign unused_shift = shift_en ^ shift_bit ^ clk ^ rst_n;
            assign hist_o       = '0;
        end else begin : g_reg
            logic [HIST_W-1:0] hist_q;

            // Hold or shift the history; clear it on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist_q <= '0;
                end else if (shift_en) begin
                    if (HIST_W == 1) hist_q <= shift_bit;
                    else             hist_q <= {hist_q[HIST_W-2:0], shift_bit};
                end
            end

            assign hist_o = hist_q;

            // R7: new outcome appears at bit 0 after a resolve
            a_r7_new_bit: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> hist_q[0] == $past(shift_bit));

            // R7: history holds when nothing resolves
            a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!shift_en && $past(rst_n)) |=> $stable(hist_q));

            if (HIST_W >= 2) begin : g_shift_chk
                // R7: older outcomes move up by one position
                a_r7_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
                    shift_en |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));
            end
        end
    endgenerate

endmodule

// File: rtl/gcp_index.sv
// Forms the counter-table index from a PC and a history value.
// The selected PC bits are the high part and the history is the low part.
// Assumes PC_LSB >= 1 and PC_LSB + ADDR_BITS < PC_W.
module gcp_index #(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int ADDR_BITS = 8,
    parameter int HIST_W    = 2,
    parameter int HW_P      = (HIST_W > 0) ? HIST_W : 1,
    parameter int IDX_W     = ADDR_BITS + HIST_W
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [HW_P-1:0]  hist,
    output logic [IDX_W-1:0] idx
);

    localparam int PC_HI = PC_LSB + ADDR_BITS;

    logic [ADDR_BITS-1:0] addr_part;
    logic                 unused_pc_bits;

    assign addr_part      = pc[PC_LSB +: ADDR_BITS];
    assign unused_pc_bits = ^{pc[PC_W-1:PC_HI], pc[PC_LSB-1:0]};

    generate
        if (HIST_W == 0) begin : g_addr_only
            logic unused_hist;
            assign unused_hist = ^hist;
            assign idx         = addr_part;
        end else begin : g_addr_hist
            assign idx = {addr_part, hist[HIST_W-1:0]};
        end
    endgenerate

endmodule

// File: rtl/gcp_ctr_table.sv
// Untagged table of 2-bit saturating direction counters.
// One combinational read port and one write port that moves the addressed
// counter one step toward the outcome. A read of the entry being written in
// the same cycle returns the value from before the update.
module gcp_ctr_table
    import gcp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_e             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int ENTRIES = 2 ** IDX_W;

    ctr_e tbl [ENTRIES];

    // Reset all counters to weak-not-taken; otherwise step the addressed one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_WNT;
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
        end
    end

    assign rd_ctr = tbl[rd_idx];

    // R4: a taken outcome never lowers the updated counter
    a_r4_taken_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken) |=> tbl[$past(wr_idx)] >= $past(tbl[wr_idx]));

    // R4: a not-taken outcome never raises the updated counter
    a_r4_nt_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken) |=> tbl[$past(wr_idx)] <= $past(tbl[wr_idx]));

    // R4: saturation at the top, no wrap to zero
    a_r4_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && tbl[wr_idx] == CTR_ST) |=> tbl[$past(wr_idx)] == CTR_ST);

    // R4: saturation at the bottom, no wrap to three
    a_r4_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && tbl[wr_idx] == CTR_SNT) |=> tbl[$past(wr_idx)] == CTR_SNT);

    // R6: an entry not addressed by the write keeps its value (checked at the read port)
    a_r6_other_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_idx != wr_idx && $past(rst_n)) |=> tbl[$past(rd_idx)] == $past(rd_ctr));

endmodule

// File: rtl/gcp_predictor.sv
// Global-history correlating branch direction predictor (top level).
// The lookup is combinational on lk_pc and the current history. The resolve
// updates one counter, selected by rs_pc and the returned rs_hist, and
// shifts rs_taken into the history. Assumes at most one resolve per cycle.
module gcp_predictor
    import gcp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int ADDR_BITS = 8,
    parameter int HIST_W    = 2,
    localparam int HW_P     = (HIST_W > 0) ? HIST_W : 1,
    localparam int IDX_W    = ADDR_BITS + HIST_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_pred,
    output logic [HW_P-1:0] lk_hist,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_taken,
    input  logic [HW_P-1:0] rs_hist
);

    logic [HW_P-1:0]  hist_cur;
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] rs_idx;
    ctr_e             lk_ctr;

    gcp_hist_reg #(.HIST_W(HIST_W), .HW_P(HW_P)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (rs_valid),
        .shift_bit (rs_taken),
        .hist_o    (hist_cur)
    );

    gcp_index #(
        .PC_W(PC_W), .PC_LSB(PC_LSB), .ADDR_BITS(ADDR_BITS),
        .HIST_W(HIST_W), .HW_P(HW_P), .IDX_W(IDX_W)
    ) u_lk_index (
        .pc   (lk_pc),
        .hist (hist_cur),
        .idx  (lk_idx)
    );

    gcp_index #(
        .PC_W(PC_W), .PC_LSB(PC_LSB), .ADDR_BITS(ADDR_BITS),
        .HIST_W(HIST_W), .HW_P(HW_P), .IDX_W(IDX_W)
    ) u_rs_index (
        .pc   (rs_pc),
        .hist (rs_hist),
        .idx  (rs_idx)
    );

    gcp_ctr_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_ctr   (lk_ctr),
        .wr_en    (rs_valid),
        .wr_idx   (rs_idx),
        .wr_taken (rs_taken)
    );

    assign lk_pred = lk_ctr[1];
    assign lk_hist = hist_cur;

    // R1: the first cycle after reset predicts not taken with cleared history
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!lk_pred && lk_hist == '0));

endmodule

// File: tb/gcp_predictor_bench.sv
// Self-checking bench for gcp_predictor: a vector table walked by one loop,
// followed by directed reset and corner-case checks.
module gcp_predictor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_pred;
    logic [1:0]  lk_hist;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_pc = '0;
    logic        rs_taken = 1'b0;
    logic [1:0]  rs_hist = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gcp_predictor u_gcp_predictor (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_pc    (lk_pc),
        .lk_pred  (lk_pred),
        .lk_hist  (lk_hist),
        .rs_valid (rs_valid),
        .rs_pc    (rs_pc),
        .rs_taken (rs_taken),
        .rs_hist  (rs_hist)
    );

    // Vector: {rv, rpc[15:0], rt, rh[1:0], lpc[15:0], exp_pred, exp_hist[1:0]}
    // A = 0x100 (PC[9:2]=0x40), B = 0x204 (0x81), C = 0x108 (0x42)
    localparam int NV = 18;
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 16'h0000, 1'b0, 2'd0, 16'h0100, 1'b0, 2'd0}, // 0 R1 A,h0=1
        {1'b1, 16'h0100, 1'b1, 2'd0, 16'h0100, 1'b0, 2'd1}, // 1 R3 A,h0->2; read A,h1=1
        {1'b1, 16'h0100, 1'b1, 2'd1, 16'h0100, 1'b0, 2'd3}, // 2 A,h1->2; read A,h3=1
        {1'b1, 16'h0204, 1'b0, 2'd3, 16'h0100, 1'b0, 2'd2}, // 3 B,h3->0; read A,h2=1
        {1'b1, 16'h0204, 1'b0, 2'd2, 16'h0100, 1'b1, 2'd0}, // 4 R2 B,h2->0; read A,h0=2
        {1'b1, 16'h0100, 1'b1, 2'd0, 16'h0100, 1'b1, 2'd1}, // 5 A,h0->3; read A,h1=2
        {1'b1, 16'h0100, 1'b1, 2'd0, 16'h0204, 1'b0, 2'd3}, // 6 R8 stale h0, A,h0 sat 3; read B,h3=0
        {1'b1, 16'h0100, 1'b0, 2'd0, 16'h0204, 1'b0, 2'd2}, // 7 A,h0->2; read B,h2=0
        {1'b1, 16'h0204, 1'b0, 2'd2, 16'h0100, 1'b1, 2'd0}, // 8 R5 B,h2 sat 0; read A,h0=2 still taken
        {1'b1, 16'h0100, 1'b0, 2'd0, 16'h0100, 1'b0, 2'd0}, // 9 R5 A,h0->1 flips
        {1'b1, 16'h0100, 1'b1, 2'd0, 16'h0502, 1'b1, 2'd1}, // 10 R6 alias 0x502 reads A,h1=2
        {1'b0, 16'h0000, 1'b0, 2'd0, 16'h0100, 1'b1, 2'd1}, // 11 R7 no resolve, hist held
        {1'b1, 16'h0108, 1'b1, 2'd1, 16'h0108, 1'b0, 2'd3}, // 12 R6 C,h1->2; C,h3 still 1
        {1'b1, 16'h0108, 1'b1, 2'd3, 16'h0108, 1'b1, 2'd3}, // 13 C,h3->2
        {1'b1, 16'h0108, 1'b0, 2'd3, 16'h0100, 1'b0, 2'd2}, // 14 C,h3->1; read A,h2=1
        {1'b1, 16'h0100, 1'b1, 2'd2, 16'h0100, 1'b1, 2'd1}, // 15 A,h2->2; read A,h1=2
        {1'b1, 16'h0204, 1'b1, 2'd2, 16'h0204, 1'b0, 2'd3}, // 16 R4 B,h2 0->1; read B,h3=0
        {1'b1, 16'h0204, 1'b0, 2'd3, 16'h0204, 1'b0, 2'd2}  // 17 R4 B,h3 sat 0; B,h2=1 (no wrap)
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one optional resolve and a lookup, then sample after the edge.
    task automatic step(input logic rv, input logic [31:0] rpc, input logic rt,
                        input logic [1:0] rh, input logic [31:0] lpc);
        @(negedge clk);
        rs_valid = rv; rs_pc = rpc; rs_taken = rt; rs_hist = rh; lk_pc = lpc;
        @(negedge clk);
        rs_valid = 1'b0;
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state seen at several addresses
        lk_pc = 32'h0000_0100; #1;
        check("R1 pred", {2'b0, lk_pred}, 3'd0);
        check("R9 hist", {1'b0, lk_hist}, 3'd0);
        lk_pc = 32'hFFFF_FFFC; #1;
        check("R1 pred far", {2'b0, lk_pred}, 3'd0);

        for (int v = 0; v < NV; v++) begin
            step(VEC[v][38], {16'h0, VEC[v][37:22]}, VEC[v][21], VEC[v][20:19],
                 {16'h0, VEC[v][18:3]});
            check($sformatf("R2/R3 vec%0d pred", v), {2'b0, lk_pred}, {2'b0, VEC[v][2]});
            check($sformatf("R7/R9 vec%0d hist", v), {1'b0, lk_hist}, {1'b0, VEC[v][1:0]});
        end

        // R5: strong-taken survives one miss. Train D=0x3FC, h=0 three times.
        rst_n = 1'b0; step(1'b0, 0, 1'b0, 2'd0, 32'h3FC); rst_n = 1'b1;
        step(1'b1, 32'h3FC, 1'b1, 2'd0, 32'h3FC);
        step(1'b1, 32'h3FC, 1'b1, 2'd0, 32'h3FC);
        step(1'b1, 32'h3FC, 1'b1, 2'd0, 32'h3FC); // D,h0 = 3, hist = 11
        step(1'b1, 32'h3FC, 1'b0, 2'd0, 32'h3FC); // D,h0 = 2, hist = 10
        step(1'b1, 32'h000, 1'b0, 2'd1, 32'h3FC); // hist = 00, E,h1 -> 0
        check("R5 one miss keeps taken", {2'b0, lk_pred}, 3'd1);
        check("R7 hist after two NT", {1'b0, lk_hist}, 3'd0);
        // R6: high PC bits ignored; same counter seen at 0xFFFF_FFFC
        lk_pc = 32'hFFFF_FFFC; #1;
        check("R6 high bits ignored", {2'b0, lk_pred}, 3'd1);
        step(1'b1, 32'h3FC, 1'b0, 2'd0, 32'h3FC); // D,h0 = 1, hist = 00
        check("R5 second miss flips", {2'b0, lk_pred}, 3'd0);

        // R8: resolve with stale history must not touch the register's entry
        step(1'b1, 32'h3FC, 1'b1, 2'd3, 32'h3FC); // D,h3 -> 2, hist = 01
        step(1'b1, 32'h3FC, 1'b1, 2'd1, 32'h3FC); // D,h1 -> 2, hist = 11
        check("R8 returned history selects", {2'b0, lk_pred}, 3'd1);

        // R1: mid-run reset clears trained state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 reset clears hist", {1'b0, lk_hist}, 3'd0);
        lk_pc = 32'h100; #1;
        check("R1 reset clears ctr", {2'b0, lk_pred}, 3'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule